// File: doc/BRIEF.md
# Asynchronous SRAM access sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 32K bytes (15-bit word address, 8-bit data). The host offers one read or one write at a time over a valid/ready handshake. The block then produces the memory's three active-low strobes (chip select, write strobe, output enable) together with the address and an 8-bit data bus. The data bus is split into an outgoing byte, an incoming byte and a drive-enable for the pad.

Every access lasts a whole number of clock periods, `CYC_CLKS`, and the same value sets both read and write cycles. A read asserts output enable only for its final `OE_CLKS` periods. It samples the incoming byte at the clock edge that closes the access and hands it to the host with a one-cycle valid strobe. A write keeps output enable high throughout. Its write strobe falls only after the address has settled and rises while chip select is still low. The pad driver switches on only after the write strobe is low and stays on through the rising edge. Chip select returns high whenever no access is running, which keeps the memory in standby. After a write, one extra cycle is spent with chip select high before the host is served again.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While the synchronous reset is sampled high, the outputs after that edge are: mem_ce_n, mem_we_n and mem_oe_n = 1, mem_dq_oe = 0, req_ready = 1, rd_valid = 0, and mem_addr and mem_dq_out = 0.
- R2: Whenever req_ready is 1 (no access in progress), mem_ce_n is 1.
- R3: A read accepted at clock edge k holds mem_ce_n at 0 and mem_we_n at 1 for the CYC_CLKS cycles that follow edge k. mem_oe_n is 0 only in the last OE_CLKS of those cycles.
- R4: At the edge that ends the last read cycle, the block captures mem_dq_in into rd_data and raises rd_valid for exactly one cycle. That is the same cycle in which req_ready returns to 1.
- R5: A write accepted at edge k holds mem_ce_n at 0 and mem_oe_n at 1 for the CYC_CLKS cycles after edge k. Counting those cycles from 0, mem_we_n is 0 in cycles 1 through CYC_CLKS-2, so it rises at the start of the last cycle while mem_ce_n is still 0.
- R6: mem_dq_oe is 1 only in write cycles 2 through CYC_CLKS-1. It is never 1 while mem_oe_n is 0. mem_dq_out holds the accepted write byte while driven.
- R7: After the last write cycle, one cycle follows with mem_ce_n = 1, mem_dq_oe = 0 and req_ready = 0 before req_ready returns to 1.
- R8: req_ready is 0 from the edge that accepts a request until the access, including any post-write cycle, completes. req_valid has no effect while req_ready is 0.
- R9: mem_addr holds the address accepted with the request for the whole access, whatever req_addr does meanwhile. Both ends of the address range (0 and 32767) reach the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Byte to write |
| rd_data | output | 8 | Byte returned by the last read |
| rd_valid | output | 1 | One-cycle strobe marking rd_data |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dq_out | output | 8 | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Pad driver enable for mem_dq_out |
| mem_dq_in | input | 8 | Byte seen on the memory data pins |

## Verification
The bench drives isolated writes and reads with idle gaps between them. These show the strobe shapes of each access kind with no overlap. It also drives streams in which req_valid never drops, and these expose any early acceptance while busy as well as a missing post-write cycle before a read. Reads follow writes to the same address, to the end addresses 0 and 32767, and to never-written locations. A model memory returns a marker byte whenever its outputs are off, so that a capture taken outside the output-enable window, or a write latched without data on the bus, appears as a wrong byte. Request fields are scrambled right after acceptance to show that the address and data presented to the memory come only from the latched request.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    localparam int unsigned MEM_ADDR_W = 15;
    localparam int unsigned MEM_DATA_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2,
        PH_GAP   = 2'd3
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic dq_drive;
        logic host_rdy;
    } pins_t;

    localparam pins_t PINS_RESET = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                     dq_drive: 1'b0, host_rdy: 1'b1};

    // Pin levels for a given phase and cycle index inside the access.
    function automatic pins_t pins_for(phase_e ph, int unsigned idx,
                                       int unsigned cyc, int unsigned oe_clks);
        pins_t p;
        p          = PINS_RESET;
        p.host_rdy = 1'b0;
        unique case (ph)
            PH_IDLE: p.host_rdy = 1'b1;
            PH_READ: begin
                p.ce_n = 1'b0;
                p.oe_n = (idx + oe_clks < cyc);
            end
            PH_WRITE: begin
                p.ce_n     = 1'b0;
                p.we_n     = !((idx >= 1) && (idx + 2 <= cyc));
                p.dq_drive = (idx >= 2);
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
    parameter int unsigned CYC_CLKS = 4,
    parameter int unsigned IDX_W    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    output logic [IDX_W-1:0] idx_q,
    output logic [IDX_W-1:0] idx_nxt,
    output logic             last
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CYC_CLKS - 1);

    always_comb begin
        if (clr)
            idx_nxt = '0;
        else if (adv)
            idx_nxt = idx_q + 1'b1;
        else
            idx_nxt = idx_q;
    end

    assign last = (idx_q == IDX_LAST);

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else
            idx_q <= idx_nxt;
    end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_seq_pkg::*;
#(
    parameter int unsigned CYC_CLKS = 4,
    parameter int unsigned OE_CLKS  = 2,
    parameter int unsigned IDX_W    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             last,
    input  logic [IDX_W-1:0] idx_nxt,
    output logic             clr,
    output logic             adv,
    output logic             accept,
    output logic             rd_done,
    output pins_t            pins_q
);

    phase_e phase_q, phase_nxt;
    pins_t  pins_nxt;

    assign accept  = req_valid && pins_q.host_rdy;
    assign rd_done = (phase_q == PH_READ) && last;

    always_comb begin
        phase_nxt = phase_q;
        clr       = 1'b0;
        adv       = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (req_valid) begin
                    phase_nxt = req_write ? PH_WRITE : PH_READ;
                    clr       = 1'b1;
                end
            end
            PH_READ: begin
                if (last) phase_nxt = PH_IDLE;
                else      adv       = 1'b1;
            end
            PH_WRITE: begin
                if (last) phase_nxt = PH_GAP;
                else      adv       = 1'b1;
            end
            PH_GAP:  phase_nxt = PH_IDLE;
            default: phase_nxt = PH_IDLE;
        endcase
    end

    // Strobes are registered so the memory pins never see decode glitches.
    assign pins_nxt = pins_for(phase_nxt, 32'(idx_nxt), CYC_CLKS, OE_CLKS);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            pins_q  <= PINS_RESET;
        end else begin
            phase_q <= phase_nxt;
            pins_q  <= pins_nxt;
        end
    end

endmodule

// File: rtl/sram_seq_datapath.sv
module sram_seq_datapath #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rd_data_q,
    output logic              rd_valid_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q     <= '0;
            wdata_q    <= '0;
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q <= req_addr;
                if (req_write) wdata_q <= req_wdata;
            end
            if (rd_done) rd_data_q <= mem_dq_in;
            rd_valid_q <= rd_done;
        end
    end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int unsigned ADDR_W   = MEM_ADDR_W,
    parameter int unsigned DATA_W   = MEM_DATA_W,
    parameter int unsigned CYC_CLKS = 4,
    parameter int unsigned OE_CLKS  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int unsigned IDX_W = $clog2(CYC_CLKS);

    logic             clr, adv, last, accept, rd_done;
    logic [IDX_W-1:0] idx_q, idx_nxt;
    pins_t            pins_q;

    sram_seq_timer #(.CYC_CLKS(CYC_CLKS), .IDX_W(IDX_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .adv    (adv),
        .idx_q  (idx_q),
        .idx_nxt(idx_nxt),
        .last   (last)
    );

    sram_seq_fsm #(.CYC_CLKS(CYC_CLKS), .OE_CLKS(OE_CLKS), .IDX_W(IDX_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .last     (last),
        .idx_nxt  (idx_nxt),
        .clr      (clr),
        .adv      (adv),
        .accept   (accept),
        .rd_done  (rd_done),
        .pins_q   (pins_q)
    );

    sram_seq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_done   (rd_done),
        .mem_dq_in (mem_dq_in),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_out),
        .rd_data_q (rd_data),
        .rd_valid_q(rd_valid)
    );

    assign mem_ce_n  = pins_q.ce_n;
    assign mem_we_n  = pins_q.we_n;
    assign mem_oe_n  = pins_q.oe_n;
    assign mem_dq_oe = pins_q.dq_drive;
    assign req_ready = pins_q.host_rdy;

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
    parameter int unsigned ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rd_valid,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr
);

    // R1: reset drives the strobes inactive and releases the bus
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rd_valid));

    // R2: no access in progress means standby
    a_r2_standby: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mem_ce_n);

    // R3: output enable only during a selected, non-writing cycle
    a_r3_oe_in_read: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n));

    // R4: read strobe lasts one cycle and coincides with ready
    a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
    a_r4_valid_ready: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> req_ready);

    // R5: write strobe only while selected and outputs disabled
    a_r5_we_window: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));

    // R6: driver never fights the memory outputs
    a_r6_no_contention: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);
    a_r6_drive_after_we: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> !mem_we_n);
    a_r6_data_at_we_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n));

    // R7: driver release is followed by a deselected, busy cycle
    a_r7_post_write_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_dq_oe) |-> (mem_ce_n && !req_ready));

    // R9: address steady while the memory stays selected
    a_r9_addr_steady: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_ready(req_ready),
    .rd_valid (rd_valid),
    .mem_ce_n (mem_ce_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_dq_oe(mem_dq_oe),
    .mem_addr (mem_addr)
);

// File: tb/sim_sram_seq_ctrl.sv
module sim_sram_seq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int CYC        = 5;
    localparam int OEC        = 2;
    localparam int AW         = 15;
    localparam int DW         = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr  = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rd_valid;
    logic [DW-1:0] rd_data;
    logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_seq_ctrl #(.CYC_CLKS(CYC), .OE_CLKS(OEC)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // ---------------- memory device model ----------------
    logic [DW-1:0] sram_arr [int];
    logic [DW-1:0] ref_arr  [int];

    always @* begin
        if (mem_ce_n === 1'b0 && mem_oe_n === 1'b0 && mem_we_n === 1'b1)
            mem_dq_in = sram_arr.exists(int'(mem_addr)) ? sram_arr[int'(mem_addr)] : 8'h00;
        else
            mem_dq_in = 8'hEE;
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge mem_we_n) begin
        if (mem_ce_n === 1'b0) begin
            chk("R6", "driver on at write strobe rise", 32'(mem_dq_oe), 32'd1);
            sram_arr[int'(mem_addr)] = mem_dq_out;
        end
    end

    // ---------------- cycle reference model ----------------
    int            e_st = 0;   // 0 idle, 1 read, 2 write, 3 post-write
    int            e_i  = 0;
    logic [AW-1:0] e_addr = '0;
    logic [DW-1:0] e_wd = '0;
    logic          e_rdv = 1'b0;
    logic [DW-1:0] e_rdd = '0;
    bit            e_fresh = 1'b1;
    string         tg;

    function automatic logic [DW-1:0] ref_get(input logic [AW-1:0] a);
        return ref_arr.exists(int'(a)) ? ref_arr[int'(a)] : 8'h00;
    endfunction

    always @(negedge clk) begin
        if (!done) begin
            if (e_fresh)        tg = "R1";
            else if (e_st == 0) tg = "R2";
            else if (e_st == 1) tg = "R3";
            else if (e_st == 2) tg = "R5";
            else                tg = "R7";
            chk(tg, "ce_n", 32'(mem_ce_n), 32'(!(e_st == 1 || e_st == 2)));
            chk(tg, "we_n", 32'(mem_we_n), 32'(!(e_st == 2 && e_i >= 1 && e_i <= CYC-2)));
            chk(tg, "oe_n", 32'(mem_oe_n), 32'(!(e_st == 1 && e_i >= CYC-OEC)));
            chk(e_fresh ? "R1" : "R6", "dq_oe", 32'(mem_dq_oe), 32'(e_st == 2 && e_i >= 2));
            chk(e_fresh ? "R1" : ((e_st == 3) ? "R7" : "R8"), "ready",
                32'(req_ready), 32'(e_st == 0));
            chk(e_fresh ? "R1" : "R9", "addr", 32'(mem_addr), 32'(e_addr));
            chk(e_fresh ? "R1" : "R4", "rd_valid", 32'(rd_valid), 32'(e_rdv));
            if (e_fresh || mem_dq_oe)
                chk(e_fresh ? "R1" : "R6", "dq_out", 32'(mem_dq_out), 32'(e_wd));
            if (e_rdv) chk("R4", "rd_data", 32'(rd_data), 32'(e_rdd));
            if (req_ready) chk("R2", "standby when ready", 32'(mem_ce_n), 32'd1);
            chk("R6", "no contention", 32'(mem_dq_oe && !mem_oe_n), 32'd0);

            if (rst) begin
                e_st = 0; e_i = 0; e_addr = '0; e_wd = '0; e_rdv = 1'b0; e_rdd = '0;
                e_fresh = 1'b1;
            end else begin
                e_fresh = 1'b0;
                e_rdv   = 1'b0;
                case (e_st)
                    0: if (req_valid) begin
                        e_st   = req_write ? 2 : 1;
                        e_i    = 0;
                        e_addr = req_addr;
                        if (req_write) e_wd = req_wdata;
                    end
                    1: if (e_i == CYC-1) begin
                        e_st  = 0;
                        e_rdv = 1'b1;
                        e_rdd = ref_get(e_addr);
                    end else e_i++;
                    2: if (e_i == CYC-1) begin
                        e_st = 3;
                        ref_arr[int'(e_addr)] = e_wd;
                    end else e_i++;
                    default: e_st = 0;
                endcase
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input bit w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input bit keep);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #1;
        // R9/R8: scramble fields once accepted; they must not matter now
        req_addr  = ~a;
        req_wdata = ~d;
        req_write = ~w;
        if (!keep) req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // isolated accesses, end addresses of the range (R9)
        send(1'b1, 15'h0000, 8'hA5, 1'b0); idle(3);
        send(1'b1, 15'h7FFF, 8'h5A, 1'b0); idle(2);
        send(1'b0, 15'h0000, 8'h00, 1'b0); idle(2);
        send(1'b0, 15'h7FFF, 8'h00, 1'b0); idle(2);
        // never-written location
        send(1'b0, 15'h1234, 8'h00, 1'b0); idle(1);
        // streamed: valid never drops (R7 gap before read, R8 no early accept)
        send(1'b1, 15'h1234, 8'hFF, 1'b1);
        send(1'b0, 15'h1234, 8'h00, 1'b1);
        send(1'b1, 15'h1234, 8'h00, 1'b1);
        send(1'b0, 15'h1234, 8'h00, 1'b1);
        send(1'b0, 15'h0000, 8'h00, 1'b1);
        send(1'b1, 15'h2AAA, 8'h3C, 1'b1);
        send(1'b1, 15'h2AAA, 8'hC3, 1'b1);
        send(1'b0, 15'h2AAA, 8'h00, 1'b0);
        idle(4);
        // reset while idle returns every output to its reset value (R1)
        #1 rst = 1'b1;
        idle(2);
        #1 rst = 1'b0;
        send(1'b0, 15'h7FFF, 8'h00, 1'b0);
        idle(8);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired t=%0t", $time);
        finish_run();
    end

endmodule